// File: doc/BRIEF.md
# ALU-Shifter Function Unit

A purely combinational datapath function unit. It takes two operands `a_i` and `b_i` of `WIDTH` bits and a 4-bit function code. It returns an operation result `f_o` together with four status flags: overflow, carry, negative and zero.

The unit has three parts, each selected by the function code:
- An adder that computes A + Y + carry-in, where Y is a function of B picked by B-input steering logic.
- A bitwise logic stage.
- A one-position shifter acting on B, with serial fill bits from two inputs.

A single decoder turns the code into adder, logic, shifter and result-source controls. A register-file datapath places the unit between its operand buses and its write-back bus.

Top module: `fu_core`

## Requirements
- R1: Codes 0000 to 0111 give F = A + Y + cin (modulo 2^WIDTH). Code bits [2:1] pick Y as 00 = zero, 01 = B, 10 = ~B, 11 = all ones, and code bit [0] is cin. This yields A, A+1, A+B, A+B+1, A+~B, A−B, A−1 and A.
- R2: For codes 0000 to 0111, C is the carry out of the WIDTH-bit sum A + Y + cin.
- R3: For codes 0000 to 0111, V is 1 exactly when A and Y have the same sign bit and the sign bit of F differs from it.
- R4: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R5: Code 1100 gives F = B, and code 1111 gives F = 0.
- R6: Code 1101 gives B shifted right by one position, with the most significant bit taken from `shr_fill_i`.
- R7: Code 1110 gives B shifted left by one position, with the least significant bit taken from `shl_fill_i`.
- R8: For every code with bit [3] set, C and V are 0.
- R9: Z is 1 exactly when F is all zeros, and N equals the most significant bit of F, for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B, also the shifter source |
| fs_i | input | 4 | Function code |
| shr_fill_i | input | 1 | Bit shifted into the MSB on a right shift |
| shl_fill_i | input | 1 | Bit shifted into the LSB on a left shift |
| f_o | output | WIDTH | Result |
| v_o | output | 1 | Signed overflow |
| c_o | output | 1 | Carry out |
| n_o | output | 1 | Sign of result |
| z_o | output | 1 | Result is zero |

## Verification
The assertions watch the flag rules on every input change:
- Z and N against the result.
- C and V held low outside the adder codes.
- The constant-zero code, the pass-B code, both shift directions with their fill bits, and the two codes that return A unchanged.

Only the bench's scenarios can show the adder results, the carry and overflow across all operand pairs, and the logic operations. At 4 bits the bench sweeps every code, every operand pair and every fill combination. A 16-bit instance is driven with seeded random operands plus sign-boundary corners.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic [1:0] {
    Y_ZERO = 2'b00,
    Y_B    = 2'b01,
    Y_NOTB = 2'b10,
    Y_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    SRC_ARITH = 2'b00,
    SRC_LOGIC = 2'b01,
    SRC_SHIFT = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_ZERO  = 2'b11
  } shop_e;

  typedef struct packed {
    src_e  src;
    ysel_e ysel;
    logic  cin;
    lop_e  lop;
    shop_e shop;
  } fu_ctrl_t;

  localparam int unsigned FS_W = 4;
endpackage

// File: rtl/fu_decode.sv
module fu_decode
  import fu_pkg::*;
(
  input  logic [FS_W-1:0] fs_i,
  output fu_ctrl_t        ctrl_o
);
  always_comb begin
    ctrl_o.ysel = ysel_e'(fs_i[2:1]);
    ctrl_o.cin  = fs_i[0];
    ctrl_o.lop  = lop_e'(fs_i[1:0]);
    ctrl_o.shop = shop_e'(fs_i[1:0]);
    if (!fs_i[3])     ctrl_o.src = SRC_ARITH;
    else if (!fs_i[2]) ctrl_o.src = SRC_LOGIC;
    else              ctrl_o.src = SRC_SHIFT;
  end
endmodule

// File: rtl/fu_arith.sv
module fu_arith
  import fu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  ysel_e            ysel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   ext_sum;

  // B-input steering, one gate pair per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_yin
    assign y[i] = (b_i[i] & ysel_i[0]) | (~b_i[i] & ysel_i[1]);
  end

  assign ext_sum = {1'b0, a_i} + {1'b0, y} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o   = ext_sum[WIDTH-1:0];
  assign cout_o  = ext_sum[WIDTH];
  assign ovf_o   = (a_i[MSB] == y[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/fu_logic.sv
module fu_logic
  import fu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  lop_e             op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      LOP_AND:  res_o = a_i & b_i;
      LOP_OR:   res_o = a_i | b_i;
      LOP_XOR:  res_o = a_i ^ b_i;
      default:  res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/fu_shift.sv
module fu_shift
  import fu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  shop_e            op_i,
  input  logic             shr_fill_i,
  input  logic             shl_fill_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      SH_PASS:  res_o = b_i;
      SH_RIGHT: res_o = {shr_fill_i, b_i[WIDTH-1:1]};
      SH_LEFT:  res_o = {b_i[WIDTH-2:0], shl_fill_i};
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/fu_core.sv
module fu_core
  import fu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       fs_i,
  input  logic             shr_fill_i,
  input  logic             shl_fill_i,
  output logic [WIDTH-1:0] f_o,
  output logic             v_o,
  output logic             c_o,
  output logic             n_o,
  output logic             z_o
);
  fu_ctrl_t         ctrl;
  logic [WIDTH-1:0] arith_res, logic_res, shift_res;
  logic             arith_c, arith_v;

  fu_decode i_dec (.fs_i(fs_i), .ctrl_o(ctrl));

  fu_arith #(.WIDTH(WIDTH)) i_arith (
    .a_i(a_i), .b_i(b_i), .ysel_i(ctrl.ysel), .cin_i(ctrl.cin),
    .sum_o(arith_res), .cout_o(arith_c), .ovf_o(arith_v)
  );

  fu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i(a_i), .b_i(b_i), .op_i(ctrl.lop), .res_o(logic_res)
  );

  fu_shift #(.WIDTH(WIDTH)) i_shift (
    .b_i(b_i), .op_i(ctrl.shop), .shr_fill_i(shr_fill_i),
    .shl_fill_i(shl_fill_i), .res_o(shift_res)
  );

  always_comb begin
    unique case (ctrl.src)
      SRC_ARITH: f_o = arith_res;
      SRC_LOGIC: f_o = logic_res;
      default:   f_o = shift_res;
    endcase
  end

  // carry and overflow only meaningful on the adder path
  assign c_o = (ctrl.src == SRC_ARITH) & arith_c;
  assign v_o = (ctrl.src == SRC_ARITH) & arith_v;
  assign n_o = f_o[WIDTH-1];
  assign z_o = ~|f_o;
endmodule

// File: rtl/fu_core_chk.sv
module fu_core_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       fs_i,
  input logic             shr_fill_i,
  input logic             shl_fill_i,
  input logic [WIDTH-1:0] f_o,
  input logic             v_o,
  input logic             c_o,
  input logic             n_o,
  input logic             z_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, fs_i, shr_fill_i, shl_fill_i})) begin
      a_r9_zero_flag: assert (z_o == (f_o == '0)) else $error("R9 zero flag");
      a_r9_sign_flag: assert (n_o == f_o[WIDTH-1]) else $error("R9 sign flag");
      a_r8_no_cv: assert (!fs_i[3] || (!c_o && !v_o)) else $error("R8 c/v set");
      a_r5_zero_code: assert (fs_i != 4'b1111 || f_o == '0) else $error("R5 zero code");
      a_r5_pass_b: assert (fs_i != 4'b1100 || f_o == b_i) else $error("R5 pass B");
      a_r6_shift_right: assert (fs_i != 4'b1101 ||
        f_o == {shr_fill_i, b_i[WIDTH-1:1]}) else $error("R6 right shift");
      a_r7_shift_left: assert (fs_i != 4'b1110 ||
        f_o == {b_i[WIDTH-2:0], shl_fill_i}) else $error("R7 left shift");
      a_r1_transfer_a: assert (!(fs_i == 4'b0000 || fs_i == 4'b0111) || f_o == a_i)
        else $error("R1 transfer A");
      a_r2_no_carry_a: assert (fs_i != 4'b0000 || (!c_o && !v_o)) else $error("R2 carry on A");
    end
  end
endmodule

bind fu_core fu_core_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i(a_i), .b_i(b_i), .fs_i(fs_i), .shr_fill_i(shr_fill_i),
  .shl_fill_i(shl_fill_i), .f_o(f_o), .v_o(v_o), .c_o(c_o),
  .n_o(n_o), .z_o(z_o)
);

// File: tb/test_fu_core.sv
module test_fu_core;
  localparam int unsigned WN = 4;
  localparam int unsigned WW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WN-1:0] a_n, b_n, f_n;
  logic [3:0]    fs_n;
  logic          sr_n, sl_n, v_n, c_n, n_n, z_n;

  logic [WW-1:0] a_w, b_w, f_w;
  logic [3:0]    fs_w;
  logic          sr_w, sl_w, v_w, c_w, n_w, z_w;

  fu_core #(.WIDTH(WN)) i_fu_core (
    .a_i(a_n), .b_i(b_n), .fs_i(fs_n), .shr_fill_i(sr_n), .shl_fill_i(sl_n),
    .f_o(f_n), .v_o(v_n), .c_o(c_n), .n_o(n_n), .z_o(z_n)
  );

  fu_core #(.WIDTH(WW)) i_fu_core_wide (
    .a_i(a_w), .b_i(b_w), .fs_i(fs_w), .shr_fill_i(sr_w), .shl_fill_i(sl_w),
    .f_o(f_w), .v_o(v_w), .c_o(c_w), .n_o(n_w), .z_o(z_w)
  );

  // returns {v, c, n, z, f[31:0]}
  function automatic logic [35:0] model(int w, logic [31:0] a, logic [31:0] b,
                                        logic [3:0] fs, logic sr, logic sl);
    longint unsigned mask, y, s, f;
    logic cin, c, v, sa, sy, sf;
    mask = (64'd1 << w) - 1;
    c = 1'b0; v = 1'b0;
    if (!fs[3]) begin
      case (fs[2:1])
        2'b00: y = 0;
        2'b01: y = b;
        2'b10: y = ~longint'(b) & mask;
        default: y = mask;
      endcase
      cin = fs[0];
      s = a + y + cin;
      f = s & mask;
      c = s[w];
      sa = a[w-1]; sy = y[w-1]; sf = f[w-1];
      v = (sa == sy) && (sf != sa);
    end else begin
      case (fs[2:0])
        3'b000: f = a & b;
        3'b001: f = a | b;
        3'b010: f = a ^ b;
        3'b011: f = ~longint'(a) & mask;
        3'b100: f = b;
        3'b101: f = (longint'(b) >> 1) | (longint'(sr) << (w - 1));
        3'b110: f = ((longint'(b) << 1) | sl) & mask;
        default: f = 0;
      endcase
    end
    return {v, c, f[w-1], (f == 0), f[31:0]};
  endfunction

  function automatic string f_tag(logic [3:0] fs);
    if (!fs[3]) return "R1";
    if (!fs[2]) return "R4";
    case (fs[1:0])
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, logic [3:0] fs);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s fs=%b actual=%h expected=%h", tag, fs, act, exp);
    end
  endtask

  task automatic check_all(int w, logic [31:0] a, logic [31:0] b, logic [3:0] fs,
                           logic sr, logic sl, logic [31:0] f, logic v, logic c,
                           logic n, logic z);
    logic [35:0] e;
    e = model(w, a, b, fs, sr, sl);
    check(f_tag(fs), f, e[31:0], fs);
    check(fs[3] ? "R8" : "R2", {31'd0, c}, {31'd0, e[34]}, fs);
    check(fs[3] ? "R8" : "R3", {31'd0, v}, {31'd0, e[35]}, fs);
    check("R9", {30'd0, n, z}, {30'd0, e[33], e[32]}, fs);
  endtask

  task automatic apply_n(logic [3:0] fs, logic [WN-1:0] a, logic [WN-1:0] b,
                         logic sr, logic sl);
    @(posedge clk);
    fs_n = fs; a_n = a; b_n = b; sr_n = sr; sl_n = sl;
    @(negedge clk);
    check_all(WN, 32'(a), 32'(b), fs, sr, sl, 32'(f_n), v_n, c_n, n_n, z_n);
  endtask

  task automatic apply_w(logic [3:0] fs, logic [WW-1:0] a, logic [WW-1:0] b,
                         logic sr, logic sl);
    @(posedge clk);
    fs_w = fs; a_w = a; b_w = b; sr_w = sr; sl_w = sl;
    @(negedge clk);
    check_all(WW, 32'(a), 32'(b), fs, sr, sl, 32'(f_w), v_w, c_w, n_w, z_w);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    fs_n = '0; a_n = '0; b_n = '0; sr_n = 0; sl_n = 0;
    fs_w = '0; a_w = '0; b_w = '0; sr_w = 0; sl_w = 0;
    // idle state: all inputs zero gives F = 0 with only Z set (R9)
    @(negedge clk);
    check("R9", {27'd0, f_n, v_n, c_n, n_n, z_n}, 32'd1, fs_n);
    // directed: R3 overflow corners, R2 borrow on A-1 from zero
    apply_n(4'b0010, 4'b0111, 4'b0001, 0, 0);
    apply_n(4'b0101, 4'b1000, 4'b0001, 0, 0);
    apply_n(4'b0110, 4'b0000, 4'b0000, 0, 0);
    apply_n(4'b0110, 4'b1000, 4'b0000, 0, 0);
    // exhaustive 4-bit sweep: R1..R9
    for (int fs = 0; fs < 16; fs++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int s = 0; s < 4; s++)
            apply_n(4'(fs), 4'(a), 4'(b), s[1], s[0]);
    // wide corners and random: R1..R9
    apply_w(4'b0010, 16'h7fff, 16'h0001, 0, 0);
    apply_w(4'b0101, 16'h8000, 16'h0001, 0, 0);
    apply_w(4'b0001, 16'hffff, 16'h0000, 0, 0);
    apply_w(4'b1101, 16'h0000, 16'h8001, 1, 0);
    apply_w(4'b1110, 16'h0000, 16'h8001, 0, 1);
    for (int i = 0; i < 3000; i++)
      apply_w(4'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule